// File: doc/BRIEF.md
# Cable Connection Debouncer

This block turns the raw bias-detect comparator output of each cable port into two filtered status bits, a Bias bit and a Connected bit. Each bit rises only after the raw input has been sampled high for a run of consecutive system clock cycles. Any low sample resets that run. A low sample clears both bits at the next clock edge. The delay therefore applies only when a cable is plugged in, never when it is pulled out. This keeps contact scrape from producing a string of status changes.

When a port's Connected bit rises, the block sends a one-cycle bus reset request to the reset sequencer. When a port's Bias or Connected bit changes and that port's interrupt enable is set, the block sends that port a one-cycle event pulse for the interrupt aggregator. A global indicator is high whenever no port is connected.

The block holds one filter and one edge detector per port. The number of ports and the two debounce lengths are parameters.

Top module: `cable_conn_monitor`

## Requirements
- R1: After reset, every Bias and Connected bit is 0, every event pulse and the bus reset request are 0, and noPortConnected is 1.
- R2: connStat[i] rises at the clock edge where biasDetect[i] has been sampled high on CONN_DEB consecutive edges. A single low sample restarts the count from zero.
- R3: biasStat[i] rises at the clock edge where biasDetect[i] has been sampled high on BIAS_DEB consecutive edges. BIAS_DEB must be no greater than CONN_DEB, so Connected never stands without Bias.
- R4: A low sample of biasDetect[i] clears biasStat[i] and connStat[i] at that same edge, with no delay.
- R5: busResetReq is high for exactly the one cycle in which some port's connStat rises. It stays low when a port disconnects.
- R6: portEvent[i] is high for exactly one cycle whenever biasStat[i] or connStat[i] changes in that cycle while intEnable[i] is 1. portEvent[i] stays 0 on any change while intEnable[i] is 0.
- R7: noPortConnected is 1 exactly when every connStat bit is 0.
- R8: Ports are independent. Activity on one port leaves the status bits and events of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| biasDetect | input | NUM_PORTS | Raw bias comparator output, one bit per port |
| intEnable | input | NUM_PORTS | Per-port event enable |
| biasStat | output | NUM_PORTS | Debounced Bias status |
| connStat | output | NUM_PORTS | Debounced Connected status |
| portEvent | output | NUM_PORTS | One-cycle status-change event per port |
| busResetReq | output | 1 | One-cycle bus reset request on a new connection |
| noPortConnected | output | 1 | High when no port is connected |

## Verification
A miscounting debounce counter shows up at the status ports. Connected or Bias then rises one or more cycles early or late, measured from the first high sample. Or a glitch train whose runs are shorter than the window produces a connection, and with it a reset request. A counter that is not cleared on a low sample makes a broken run still reach the threshold, and the interrupted-run pattern exposes this within CONN_DEB cycles. A wrong enable gate or a wrong edge detector shows up as an event or reset pulse that is missing, doubled or one cycle off, and every cycle of a width sweep makes that visible.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  // Per-port status-change strobes, valid in the cycle before the status flops update
  typedef struct packed {
    logic biasUp;
    logic biasDown;
    logic connUp;
    logic connDown;
  } edgeStrobe_t;
endpackage

// File: rtl/cbl_debounce_path.sv
module cbl_debounce_path #(
  parameter int NUM_PORTS = 3,
  parameter int BIAS_DEB  = 64,
  parameter int CONN_DEB  = 2048
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_PORTS-1:0]                 biasDetect,
  output logic [NUM_PORTS-1:0]                 biasStat,
  output logic [NUM_PORTS-1:0]                 connStat,
  output cbl_pkg::edgeStrobe_t [NUM_PORTS-1:0] strobes
);
  localparam int BW = (BIAS_DEB < 2) ? 1 : $clog2(BIAS_DEB);
  localparam int CW = (CONN_DEB < 2) ? 1 : $clog2(CONN_DEB);
  localparam logic [BW-1:0] BIAS_LAST = BW'(BIAS_DEB - 1);
  localparam logic [CW-1:0] CONN_LAST = CW'(CONN_DEB - 1);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [BW-1:0] biasCnt;
    logic [CW-1:0] connCnt;
    logic          biasHit;
    logic          connHit;

    assign biasHit = biasDetect[p] && !biasStat[p] && (biasCnt == BIAS_LAST);
    assign connHit = biasDetect[p] && !connStat[p] && (connCnt == CONN_LAST);

    assign strobes[p].biasUp   = biasHit;
    assign strobes[p].connUp   = connHit;
    assign strobes[p].biasDown = !biasDetect[p] && biasStat[p];
    assign strobes[p].connDown = !biasDetect[p] && connStat[p];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        biasCnt     <= '0;
        biasStat[p] <= 1'b0;
      end else if (!biasDetect[p]) begin
        biasCnt     <= '0;
        biasStat[p] <= 1'b0;
      end else if (!biasStat[p]) begin
        if (biasHit) biasStat[p] <= 1'b1;
        else         biasCnt     <= biasCnt + BW'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        connCnt     <= '0;
        connStat[p] <= 1'b0;
      end else if (!biasDetect[p]) begin
        connCnt     <= '0;
        connStat[p] <= 1'b0;
      end else if (!connStat[p]) begin
        if (connHit) connStat[p] <= 1'b1;
        else         connCnt     <= connCnt + CW'(1);
      end
    end

    // R4
    drop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !biasDetect[p] |=> (!biasStat[p] && !connStat[p]));
    // R3
    conn_needs_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      connStat[p] |-> biasStat[p]);
    // R2
    rise_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connStat[p]) |-> $past(biasDetect[p]));
  end
endmodule

// File: rtl/cbl_event_ctrl.sv
module cbl_event_ctrl #(
  parameter int NUM_PORTS = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_PORTS-1:0]                 intEnable,
  input  logic [NUM_PORTS-1:0]                 connStat,
  input  cbl_pkg::edgeStrobe_t [NUM_PORTS-1:0] strobes,
  output logic [NUM_PORTS-1:0]                 portEvent,
  output logic                                 busResetReq,
  output logic                                 noPortConnected
);
  logic [NUM_PORTS-1:0] anyChange;
  logic [NUM_PORTS-1:0] newConn;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chg
    assign anyChange[p] = strobes[p].biasUp | strobes[p].biasDown |
                          strobes[p].connUp | strobes[p].connDown;
    assign newConn[p]   = strobes[p].connUp;

    // R5
    reset_on_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connStat[p]) |-> busResetReq);
    // R6
    event_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      portEvent[p] |-> $past(intEnable[p]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      portEvent   <= '0;
      busResetReq <= 1'b0;
    end else begin
      portEvent   <= anyChange & intEnable;
      busResetReq <= |newConn;
    end
  end

  assign noPortConnected = ~|connStat;

  // R5
  no_reset_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busResetReq |-> !noPortConnected);
endmodule

// File: rtl/cable_conn_monitor.sv
module cable_conn_monitor #(
  parameter int NUM_PORTS = 3,
  parameter int BIAS_DEB  = 64,
  parameter int CONN_DEB  = 2048
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] biasDetect,
  input  logic [NUM_PORTS-1:0] intEnable,
  output logic [NUM_PORTS-1:0] biasStat,
  output logic [NUM_PORTS-1:0] connStat,
  output logic [NUM_PORTS-1:0] portEvent,
  output logic                 busResetReq,
  output logic                 noPortConnected
);
  cbl_pkg::edgeStrobe_t [NUM_PORTS-1:0] strobes;

  cbl_debounce_path #(
    .NUM_PORTS(NUM_PORTS), .BIAS_DEB(BIAS_DEB), .CONN_DEB(CONN_DEB)
  ) i_path (
    .clk(clk), .rst_n(rst_n), .biasDetect(biasDetect),
    .biasStat(biasStat), .connStat(connStat), .strobes(strobes)
  );

  cbl_event_ctrl #(.NUM_PORTS(NUM_PORTS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .intEnable(intEnable), .connStat(connStat),
    .strobes(strobes), .portEvent(portEvent), .busResetReq(busResetReq),
    .noPortConnected(noPortConnected)
  );
endmodule

// File: tb/test_cable_conn_monitor.sv
module test_cable_conn_monitor;
  localparam int NP = 3;
  localparam int BD = 3;
  localparam int CD = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] biasDetect = '0;
  logic [NP-1:0] intEnable = '0;
  logic [NP-1:0] biasStat, connStat, portEvent;
  logic          busResetReq, noPortConnected;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cable_conn_monitor #(.NUM_PORTS(NP), .BIAS_DEB(BD), .CONN_DEB(CD)) i_cable_conn_monitor (
    .clk(clk), .rst_n(rst_n), .biasDetect(biasDetect), .intEnable(intEnable),
    .biasStat(biasStat), .connStat(connStat), .portEvent(portEvent),
    .busResetReq(busResetReq), .noPortConnected(noPortConnected)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkAll(input string req, input logic [NP-1:0] eB, input logic [NP-1:0] eC,
                        input logic [NP-1:0] eE, input logic eR);
    chk({req, " bias"},  8'(biasStat),  8'(eB));
    chk({req, " conn"},  8'(connStat),  8'(eC));
    chk({req, " event"}, 8'(portEvent), 8'(eE));
    chk({req, " rst"},   8'(busResetReq), 8'(eR));
    chk({req, " R7 nopc"}, 8'(noPortConnected), 8'(eC == '0));
  endtask

  // raw high on port p for w edges, then low; checks R2 R3 R4 R5 R6 R8 each cycle
  task automatic runPulse(input int p, input int w, input bit en);
    logic [NP-1:0] one;
    one = NP'(1) << p;
    intEnable = en ? one : '0;
    biasDetect = one;
    for (int n = 1; n <= w; n++) begin
      @(posedge clk); @(negedge clk);
      chkAll("R2/R3/R5/R6/R8 rise",
             (n >= BD) ? one : '0, (n >= CD) ? one : '0,
             (en && (n == BD || n == CD)) ? one : '0, (n == CD));
    end
    biasDetect = '0;
    @(posedge clk); @(negedge clk);
    chkAll("R4/R5/R6 drop", '0, '0, (en && w >= BD) ? one : '0, 1'b0);
    @(posedge clk); @(negedge clk);
    chkAll("R4 idle", '0, '0, '0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkAll("R1 reset", '0, '0, '0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chkAll("R1 after release", '0, '0, '0, 1'b0);

    for (int p = 0; p < NP; p++)
      for (int w = 1; w <= CD + 2; w++)
        runPulse(p, w, (w + p) % 2 == 0);

    // R2: glitch train of runs shorter than the window never connects
    intEnable = '1;
    for (int k = 0; k < 4; k++) begin
      biasDetect = 3'b001;
      for (int n = 1; n <= CD - 1; n++) begin
        @(posedge clk); @(negedge clk);
        chk("R2 train conn", 8'(connStat), 8'h0);
        chk("R2 train rst", 8'(busResetReq), 8'h0);
      end
      biasDetect = '0;
      @(posedge clk); @(negedge clk);
      chk("R2 train drop conn", 8'(connStat), 8'h0);
    end

    // R8/R7/R5: port 0 connected, then port 2 connects; port 0 drops
    intEnable = '0;
    biasDetect = 3'b001;
    repeat (CD) @(posedge clk);
    @(negedge clk);
    chk("R2 p0 conn", 8'(connStat), 8'h1);
    biasDetect = 3'b101;
    for (int n = 1; n <= CD; n++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 p2 conn", 8'(connStat), (n >= CD) ? 8'h5 : 8'h1);
      chk("R5 p2 rst", 8'(busResetReq), 8'(n == CD));
      chk("R7 nopc", 8'(noPortConnected), 8'h0);
      chk("R6 disabled", 8'(portEvent), 8'h0);
    end
    biasDetect = 3'b100;
    @(posedge clk); @(negedge clk);
    chk("R4 p0 drop", 8'(connStat), 8'h4);
    chk("R5 no rst on drop", 8'(busResetReq), 8'h0);
    chk("R7 one left", 8'(noPortConnected), 8'h0);
    biasDetect = '0;
    @(posedge clk); @(negedge clk);
    chk("R7 none left", 8'(noPortConnected), 8'h1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule